// File: doc/BRIEF.md
# Dual 64-bit Down-Counting Interval Timer

This peripheral holds two independent interval timers behind one simple register bus. Each timer owns a 64-bit down-counter with a reload value, a control word and an interrupt flag. Software programs a start count, picks free-running, periodic or one-shot behaviour, and then either polls the status or takes the per-timer interrupt line. A combined line is also driven when any timer interrupts. Counting goes downward, so software that wants a rising timestamp reads the value and inverts it.

The reload value can be written two ways. A load write restarts the count at once. A background write changes only the value that the next periodic wrap uses. A per-timer size bit narrows a timer to its low 32 bits. Timer `i` occupies a 64-byte slot at byte address `i*0x40`. The bus is word addressed, with `addr[1:0]` required to be zero. Read data is combinational and returns the state after the most recent clock edge.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every control word, reload value, counter and interrupt flag is zero, so every register reads 0 and `irq`/`irq_any` are low.
- R2: Timer i's registers sit at `i*0x40` plus these offsets: 0x00 load low, 0x04 load high, 0x08 count low, 0x0C count high, 0x10 control, 0x14 interrupt clear, 0x18 raw status (bit 0), 0x1C masked status (bit 0), 0x20 background load low, 0x24 background load high. A read of an unlisted offset, a misaligned address (`addr[1:0]`≠0) or a slot at or beyond the timer count returns 0, and a write there changes nothing. `rdata` is 0 whenever `rd_en` is low.
- R3: While control bit 7 (enable) is set, the counter drops by one on every clock edge, and the count registers return its current low and high halves.
- R4: A write to either load half stores that half of the reload value and sets the counter to the whole new reload value at the same edge, whether or not the timer is enabled. This write takes precedence over that edge's count step.
- R5: A write to either background half changes only that half of the reload value and leaves the current count alone. The load and background offsets both read back the reload value.
- R6: The raw interrupt flag sets at the edge where an enabled counter steps from 1 to 0, and at no other time.
- R7: An enabled counter already at zero takes one of three next values. With control bit 0 (one-shot) set, it stays at zero and raises no further interrupt. One-shot takes priority over periodic. Otherwise, with control bit 6 (periodic) set, it reloads the reload value. With both bits clear (free-running), it wraps to all ones.
- R8: With the enable bit clear, the counter holds its value.
- R9: Any write to the interrupt-clear offset clears that timer's raw flag. If an expiry happens at the same edge, the flag stays set.
- R10: The masked status and `irq[i]` equal the raw flag ANDed with control bit 5 (interrupt enable). `irq_any` is the OR of all `irq` bits.
- R11: With control bit 1 (32-bit size) set, only the low 32 bits count, wrap and load. The count-high register reads 0, and a free-running wrap gives 0xFFFF_FFFF. The reload value keeps its full stored width.
- R12: Control bits 0, 1, 5, 6 and 7 read back as written. Every other control bit reads 0.
- R13: Writes to the count, raw status and masked status offsets have no effect.
- R14: The timers are independent. Writes to one slot never change the other timer's count, control or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (8) | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, acts at the next rising edge |
| rd_en | input | 1 | Read strobe; gates `rdata` |
| rdata | output | 32 | Combinational read data |
| irq | output | N_TIMERS (2) | Per-timer masked interrupt |
| irq_any | output | 1 | OR of all timer interrupts |

## Verification
The bench targets four corner cases. The first is an interrupt clear landing on the very edge the counter expires. A design that lets the clear win would lose that interrupt for good. The second is a background write while a periodic timer runs. If that write restarted the count, the wrap would come early. The third is the one-shot bit together with the periodic bit: the one-shot bit must win, otherwise the timer reloads and interrupts again. The fourth is the 32-bit size mode. A design that left the upper half live would show a non-zero high word or wrap to a 64-bit all-ones value. Misaligned and unmapped writes, writes to read-only offsets and cross-timer isolation are each checked at the read port, where a stray decode would show up as a changed count or control value.

// File: rtl/dit_pkg.sv
package dit_pkg;

    localparam int unsigned DW    = 32;
    localparam int unsigned OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_LOAD_LO = 6'h00;
    localparam logic [OFS_W-1:0] OFS_LOAD_HI = 6'h04;
    localparam logic [OFS_W-1:0] OFS_VAL_LO  = 6'h08;
    localparam logic [OFS_W-1:0] OFS_VAL_HI  = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_CTRL    = 6'h10;
    localparam logic [OFS_W-1:0] OFS_ICLR    = 6'h14;
    localparam logic [OFS_W-1:0] OFS_RAW     = 6'h18;
    localparam logic [OFS_W-1:0] OFS_MSK     = 6'h1C;
    localparam logic [OFS_W-1:0] OFS_BG_LO   = 6'h20;
    localparam logic [OFS_W-1:0] OFS_BG_HI   = 6'h24;

    localparam int unsigned B_ONESHOT  = 0;
    localparam int unsigned B_SIZE32   = 1;
    localparam int unsigned B_IE       = 5;
    localparam int unsigned B_PERIODIC = 6;
    localparam int unsigned B_EN       = 7;

    typedef struct packed {
        logic en;
        logic periodic;
        logic ie;
        logic size32;
        logic oneshot;
    } ctl_t;

    typedef enum logic [1:0] {
        WRAP_ALL_ONES = 2'd0,
        WRAP_RELOAD   = 2'd1,
        WRAP_HOLD     = 2'd2
    } wrap_e;

    function automatic wrap_e wrap_of(ctl_t c);
        if (c.oneshot)  return WRAP_HOLD;
        if (c.periodic) return WRAP_RELOAD;
        return WRAP_ALL_ONES;
    endfunction

    function automatic ctl_t ctl_from_word(logic [DW-1:0] w);
        ctl_t c;
        c.en       = w[B_EN];
        c.periodic = w[B_PERIODIC];
        c.ie       = w[B_IE];
        c.size32   = w[B_SIZE32];
        c.oneshot  = w[B_ONESHOT];
        return c;
    endfunction

    function automatic logic [DW-1:0] ctl_to_word(ctl_t c);
        logic [DW-1:0] w;
        w             = '0;
        w[B_EN]       = c.en;
        w[B_PERIODIC] = c.periodic;
        w[B_IE]       = c.ie;
        w[B_SIZE32]   = c.size32;
        w[B_ONESHOT]  = c.oneshot;
        return w;
    endfunction

endpackage

// File: rtl/dit_decode.sv
module dit_decode
    import dit_pkg::*;
#(
    parameter int unsigned N_TIMERS = 2,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [N_TIMERS-1:0] wr_sel,
    output logic [N_TIMERS-1:0] rd_sel,
    output logic [OFS_W-1:0]    ofs
);
    localparam int unsigned IDX_W = ADDR_W - OFS_W;

    logic aligned;

    assign aligned = (addr[1:0] == 2'b00);
    assign ofs     = addr[OFS_W-1:0];

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_sel
        logic hit;
        assign hit       = aligned && (addr[ADDR_W-1:OFS_W] == IDX_W'(i));
        assign wr_sel[i] = wr_en && hit;
        assign rd_sel[i] = rd_en && hit;
    end

endmodule

// File: rtl/dit_channel.sv
module dit_channel
    import dit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_word,
    output logic             raw_o,
    output ctl_t             ctl_o
);
    localparam int unsigned CW = 2 * DW;
    localparam logic [CW-1:0] LOW_MASK = {{DW{1'b0}}, {DW{1'b1}}};

    typedef struct packed {
        ctl_t          ctl;
        logic [CW-1:0] cnt;
        logic [CW-1:0] rld;
        logic          raw;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] width_mask;
    logic [CW-1:0] live;
    logic [CW-1:0] rld_new;
    logic          load_hit;
    logic          expire;

    // next-state computation
    always_comb begin
        width_mask = st_q.ctl.size32 ? LOW_MASK : '1;
        live       = st_q.cnt & width_mask;
        load_hit   = wr_stb && ((ofs == OFS_LOAD_LO) || (ofs == OFS_LOAD_HI));

        rld_new = st_q.rld;
        if (wr_stb && ((ofs == OFS_LOAD_LO) || (ofs == OFS_BG_LO))) begin
            rld_new[DW-1:0] = wdata;
        end
        if (wr_stb && ((ofs == OFS_LOAD_HI) || (ofs == OFS_BG_HI))) begin
            rld_new[CW-1:DW] = wdata;
        end

        expire     = 1'b0;
        st_d       = st_q;
        st_d.rld   = rld_new;

        if (load_hit) begin
            st_d.cnt = rld_new & width_mask;
        end else if (st_q.ctl.en) begin
            if (live != '0) begin
                st_d.cnt = live - CW'(1);
                expire   = (live == CW'(1));
            end else begin
                case (wrap_of(st_q.ctl))
                    WRAP_HOLD:     st_d.cnt = '0;
                    WRAP_RELOAD:   st_d.cnt = st_q.rld & width_mask;
                    WRAP_ALL_ONES: st_d.cnt = width_mask;
                    default:       st_d.cnt = width_mask;
                endcase
            end
        end

        if (wr_stb && (ofs == OFS_CTRL)) begin
            st_d.ctl = ctl_from_word(wdata);
        end
        if (wr_stb && (ofs == OFS_ICLR)) begin
            st_d.raw = 1'b0;
        end
        if (expire) begin
            st_d.raw = 1'b1;
        end
    end

    // register readback
    always_comb begin
        case (ofs)
            OFS_LOAD_LO, OFS_BG_LO: rd_word = st_q.rld[DW-1:0];
            OFS_LOAD_HI, OFS_BG_HI: rd_word = st_q.rld[CW-1:DW];
            OFS_VAL_LO:             rd_word = live[DW-1:0];
            OFS_VAL_HI:             rd_word = live[CW-1:DW];
            OFS_CTRL:               rd_word = ctl_to_word(st_q.ctl);
            OFS_RAW:                rd_word = {{(DW-1){1'b0}}, st_q.raw};
            OFS_MSK:                rd_word = {{(DW-1){1'b0}}, st_q.raw & st_q.ctl.ie};
            default:                rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.raw;
    assign ctl_o = st_q.ctl;

endmodule

// File: rtl/dit_rdmux.sv
module dit_rdmux
    import dit_pkg::*;
#(
    parameter int unsigned N_TIMERS = 2
) (
    input  logic [N_TIMERS-1:0]    rd_sel,
    input  logic [N_TIMERS*DW-1:0] chan_words,
    output logic [DW-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (rd_sel[i]) begin
                rdata = rdata | chan_words[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int unsigned N_TIMERS = 2,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DW-1:0]       wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [DW-1:0]       rdata,
    output logic [N_TIMERS-1:0] irq,
    output logic                irq_any
);
    logic [N_TIMERS-1:0]    wr_sel;
    logic [N_TIMERS-1:0]    rd_sel;
    logic [OFS_W-1:0]       ofs;
    logic [N_TIMERS*DW-1:0] chan_words;
    logic [N_TIMERS-1:0]    raw_vec;
    logic [N_TIMERS-1:0]    en_vec;
    logic [N_TIMERS-1:0]    ie_vec;
    logic [N_TIMERS-1:0]    sz_vec;

    dit_decode #(
        .N_TIMERS (N_TIMERS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel),
        .ofs    (ofs)
    );

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_chan
        ctl_t ctl_w;

        dit_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_sel[i]),
            .ofs     (ofs),
            .wdata   (wdata),
            .rd_word (chan_words[i*DW +: DW]),
            .raw_o   (raw_vec[i]),
            .ctl_o   (ctl_w)
        );

        assign en_vec[i] = ctl_w.en;
        assign ie_vec[i] = ctl_w.ie;
        assign sz_vec[i] = ctl_w.size32;
    end

    dit_rdmux #(
        .N_TIMERS (N_TIMERS)
    ) u_rdmux (
        .rd_sel     (rd_sel),
        .chan_words (chan_words),
        .rdata      (rdata)
    );

    assign irq     = raw_vec & ie_vec;
    assign irq_any = |irq;

endmodule

// File: rtl/dit_checker.sv
module dit_checker
    import dit_pkg::*;
#(
    parameter int unsigned N_TIMERS = 2,
    parameter int unsigned ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                rd_en,
    input logic [DW-1:0]       rdata,
    input logic [N_TIMERS-1:0] irq,
    input logic [N_TIMERS-1:0] raw_vec,
    input logic [N_TIMERS-1:0] en_vec,
    input logic [N_TIMERS-1:0] sz_vec
);
    localparam int unsigned IDX_W = ADDR_W - OFS_W;

    // R2: idle bus drives zero
    a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_t
        // R6: raw flag only rises out of an enabled timer
        a_r6_raw_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw_vec[i]) |-> $past(en_vec[i]));

        // R10: masked status read agrees with the interrupt line
        a_r10_masked_matches_line: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && (addr == {IDX_W'(i), OFS_MSK})) |-> (rdata[0] == irq[i]));

        // R11: high count half is zero in 32-bit size
        a_r11_high_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && sz_vec[i] && (addr == {IDX_W'(i), OFS_VAL_HI})) |-> (rdata == '0));

        // R12: reserved control bits read as zero
        a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && (addr == {IDX_W'(i), OFS_CTRL})) |->
                ((rdata[DW-1:8] == '0) && (rdata[4:2] == 3'b000)));
    end

endmodule

bind dual_interval_timer dit_checker #(
    .N_TIMERS (N_TIMERS),
    .ADDR_W   (ADDR_W)
) u_dit_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .irq     (irq),
    .raw_vec (raw_vec),
    .en_vec  (en_vec),
    .sz_vec  (sz_vec)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [1:0]  irq;
    logic        irq_any;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dual_interval_timer u_dual_interval_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .irq     (irq),
        .irq_any (irq_any)
    );

    // behavioural reference
    logic [63:0] m_cnt [2];
    logic [63:0] m_rld [2];
    logic [7:0]  m_ctl [2];
    bit          m_raw [2];

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int t;
        logic [63:0] v;
        t = a[6];
        if (a[7] || a[1:0] != 2'b00) return 32'h0;
        v = m_ctl[t][1] ? (m_cnt[t] & 64'h0000_0000_FFFF_FFFF) : m_cnt[t];
        case (a[5:0])
            6'h00, 6'h20: return m_rld[t][31:0];
            6'h04, 6'h24: return m_rld[t][63:32];
            6'h08:        return v[31:0];
            6'h0C:        return v[63:32];
            6'h10:        return {24'h0, m_ctl[t]};
            6'h18:        return {31'h0, m_raw[t]};
            6'h1C:        return {31'h0, m_raw[t] & m_ctl[t][5]};
            default:      return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 2; t++) begin
                m_cnt[t] = '0; m_rld[t] = '0; m_ctl[t] = '0; m_raw[t] = 0;
            end
        end else begin
            for (int t = 0; t < 2; t++) begin
                bit hit, load, fired;
                logic [63:0] msk, now, nxt;
                hit   = wr_en && !addr[7] && (addr[6] == t[0]) && (addr[1:0] == 2'b00);
                load  = hit && (addr[5:0] == 6'h00 || addr[5:0] == 6'h04);
                msk   = m_ctl[t][1] ? 64'h0000_0000_FFFF_FFFF : '1;
                now   = m_cnt[t] & msk;
                nxt   = m_cnt[t];
                fired = 0;
                if (hit && (addr[5:0] == 6'h00 || addr[5:0] == 6'h20)) m_rld[t][31:0]  = wdata;
                if (hit && (addr[5:0] == 6'h04 || addr[5:0] == 6'h24)) m_rld[t][63:32] = wdata;
                if (load) nxt = m_rld[t] & msk;
                else if (m_ctl[t][7]) begin
                    if (now == 64'd1) fired = 1;
                    if (now != 0)          nxt = now - 64'd1;
                    else if (m_ctl[t][0])  nxt = 0;
                    else if (m_ctl[t][6])  nxt = m_rld[t] & msk;
                    else                   nxt = msk;
                end
                m_cnt[t] = nxt;
                if (hit && addr[5:0] == 6'h10) m_ctl[t] = wdata[7:0] & 8'hE3;
                if (hit && addr[5:0] == 6'h14) m_raw[t] = 0;
                if (fired) m_raw[t] = 1;
            end
        end
    end

    // per-cycle comparison against the reference
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !finished) begin
            logic [31:0] er;
            logic [1:0]  ei;
            er = rd_en ? m_read(addr) : 32'h0;
            ei = {m_raw[1] & m_ctl[1][5], m_raw[0] & m_ctl[0][5]};
            n_checks++;
            if (rdata !== er) begin
                n_fail++;
                $display("FAIL R3 rdata addr=%h got %h expected %h", addr, rdata, er);
            end
            n_checks++;
            if (irq !== ei || irq_any !== (|ei)) begin
                n_fail++;
                $display("FAIL R10 irq got %b/%b expected %b/%b", irq, irq_any, ei, |ei);
            end
        end
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a; rd_en = 1'b1;
        #2;
        chk(rdata, exp, tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired got 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h10, 32'h0, "R1 ctrl after reset");
        rd(8'h08, 32'h0, "R1 count after reset");
        chk({30'h0, irq}, 32'h0, "R1 irq after reset");

        // R12: control readback
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0000_00E3, "R12 ctrl readback");
        wr(8'h10, 32'h0);

        // R4 and R8: load while stopped
        wr(8'h00, 32'd10);
        rd(8'h08, 32'd10, "R4 load sets count");
        idle(5);
        rd(8'h08, 32'd10, "R8 stopped count holds");

        // R5: background write leaves count
        wr(8'h20, 32'd3);
        rd(8'h08, 32'd10, "R5 bg keeps count");
        rd(8'h00, 32'd3, "R5 load reads reload");
        rd(8'h20, 32'd3, "R5 bg reads reload");

        // R3, R6, R7 periodic
        wr(8'h00, 32'd5);
        wr(8'h04, 32'd0);
        rd(8'h04, 32'd0, "R4 load high");
        wr(8'h10, 32'h0000_00E0);
        idle(4);
        chk({30'h0, irq}, 32'h0, "R6 no irq before expiry");
        idle(1);
        chk({30'h0, irq}, 32'h1, "R6 irq at expiry");
        rd(8'h08, 32'd0, "R3 count at zero");
        rd(8'h08, 32'd5, "R7 periodic reload");
        rd(8'h1C, 32'd1, "R10 masked status");

        // R9: clear
        wr(8'h14, 32'h0);
        rd(8'h18, 32'd0, "R9 clear drops raw");
        chk({30'h0, irq}, 32'h0, "R9 irq after clear");

        // R9: clear on the expiry edge loses to the set
        wr(8'h00, 32'd4);
        wr(8'h14, 32'h0);
        idle(2);
        wr(8'h14, 32'h0);
        rd(8'h18, 32'd1, "R9 expiry beats clear");

        // R10: mask off
        wr(8'h10, 32'h0000_00C0);
        rd(8'h1C, 32'd0, "R10 masked off");
        rd(8'h18, 32'd1, "R10 raw still set");
        chk({31'h0, irq_any}, 32'h0, "R10 irq_any low");

        // R7: one-shot wins over periodic
        wr(8'h10, 32'h0000_00C1);
        wr(8'h14, 32'h0);
        wr(8'h00, 32'd2);
        idle(3);
        rd(8'h08, 32'd0, "R7 one-shot holds zero");
        rd(8'h18, 32'd1, "R7 one-shot fired");
        wr(8'h14, 32'h0);
        idle(5);
        rd(8'h18, 32'd0, "R7 one-shot no refire");
        rd(8'h08, 32'd0, "R7 one-shot still zero");

        // R7: free-running 64-bit wrap
        wr(8'h10, 32'h0000_0080);
        wr(8'h00, 32'd1);
        idle(2);
        rd(8'h08, 32'hFFFF_FFFF, "R7 free wrap low");
        rd(8'h0C, 32'hFFFF_FFFF, "R7 free wrap high");

        // R11: 32-bit size
        wr(8'h10, 32'h0000_0082);
        wr(8'h04, 32'd5);
        wr(8'h00, 32'd1);
        idle(2);
        rd(8'h08, 32'hFFFF_FFFF, "R11 low wrap");
        rd(8'h0C, 32'h0, "R11 high reads zero");
        rd(8'h04, 32'd5, "R11 reload keeps high");

        // R8: disable freezes
        wr(8'h10, 32'h0000_0002);
        rd(8'h08, 32'hFFFF_FFFB, "R8 frozen value");
        idle(4);
        rd(8'h08, 32'hFFFF_FFFB, "R8 still frozen");

        // R13: read-only offsets
        wr(8'h08, 32'h0000_1234);
        rd(8'h08, 32'hFFFF_FFFB, "R13 count write ignored");
        wr(8'h18, 32'h0);
        rd(8'h18, 32'd1, "R13 raw write ignored");

        // R2: decode
        wr(8'h11, 32'h0000_00FF);
        rd(8'h10, 32'h0000_0002, "R2 misaligned write ignored");
        rd(8'h28, 32'h0, "R2 unlisted offset");
        wr(8'h90, 32'h0000_00FF);
        rd(8'h90, 32'h0, "R2 slot beyond timers");
        addr = 8'h08;
        #2;
        chk(rdata, 32'h0, "R2 rdata zero without rd_en");
        @(negedge clk);

        // R14: second timer alone
        wr(8'h40, 32'd3);
        wr(8'h50, 32'h0000_00A0);
        idle(3);
        chk({30'h0, irq}, 32'h2, "R14 second timer irq");
        chk({31'h0, irq_any}, 32'h1, "R10 irq_any from second");
        rd(8'h08, 32'hFFFF_FFFB, "R14 first timer untouched");

        // R5: background reload on a running periodic timer
        wr(8'h50, 32'h0000_00E0);
        wr(8'h54, 32'h0);
        wr(8'h40, 32'd20);
        wr(8'h60, 32'd3);
        rd(8'h48, 32'd19, "R5 bg does not restart");
        idle(18);
        rd(8'h48, 32'd0, "R5 reaches zero");
        rd(8'h48, 32'd3, "R5 wrap uses bg value");
        rd(8'h40, 32'd3, "R5 load reads new reload");

        idle(2);
        finish_run();
    end

endmodule